// File: doc/BRIEF.md
# Matrix Keypad Scan Encoder

This block scans a grid of push-buttons wired as rows and columns. It pulls one row line low at a time, reads the column lines back, and turns the combined row-and-column picture into a small binary key number. One step of the scan runs on each pulse of a scan-enable input. That pulse comes from a slower tick generator elsewhere in the chip, typically a few kilohertz, and the block itself runs on the fast system clock. The column lines come from the outside world, so they pass through a synchronizer before they are used.

The key number is registered and changes only on scan pulses. At each pulse it reports the key found in the row that was being driven. If that row shows no key, or shows more than one key, the block reports a reserved all-ones "no key" value. Logic further downstream ignores that value. The default configuration is a 4x4 grid with 5-bit key numbers 0 to 15.

Top module: `keypad_scan_enc`

## Requirements
- R1: While `clr` is high at a rising clock edge, the next state is: the row counter at 0, `row_drv` = 4'b0111, and `key_code` = 5'b11111.
- R2: Each `scan_tick` advances `row_drv` one step through the cycle 0111 → 1110 → 1101 → 1011 → 0111. Without a tick, `row_drv` holds.
- R3: Once out of clear, exactly one bit of `row_drv` is low. Bit r low means row r is driven.
- R4: On a tick, if the driven row r sees exactly one low column c (bit c of `col_in`), then `key_code` becomes r*COLS + c. Examples: row 1110 with columns 1110 gives 0; row 0111 with columns 0111 gives 15.
- R5: On a tick with no low column, `key_code` becomes the reserved value 5'b11111.
- R6: On a tick with two or more low columns, `key_code` becomes 5'b11111.
- R7: `key_code` changes only on clock edges where `scan_tick` or `clr` is high.
- R8: Columns go through a two-stage synchronizer. A tick at edge T decodes the column value that was present at edge T-2. A change that lands after edge T-2 is first seen at the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active high |
| scan_tick | input | 1 | One-cycle scan-enable pulse; advances the scan and updates the key number |
| col_in | input | COLS | Asynchronous column sense lines, low = contact closed |
| row_drv | output | ROWS | Row drive lines, exactly one low |
| key_code | output | CODE_W | Registered key number, all ones when no single key is seen |

## Verification
The bench builds the default configuration: four rows, four columns, 5-bit codes and two synchronizer stages. That grid is small enough to press every one of the sixteen keys alone and follow it through a full row rotation. Two-key patterns in one row and in different rows are added, along with a fully pressed grid. A direct column override then places a column change exactly one edge before and exactly two edges before a tick. This pins the synchronizer latency.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

   // Number of zero bits among the low w bits of v.
   function automatic int zero_count(input logic [31:0] v, input int w);
      int n;
      n = 0;
      for (int i = 0; i < w; i++) begin
         if (!v[i]) n++;
      end
      return n;
   endfunction

   // Index of the lowest zero bit among the low w bits of v (0 if none).
   function automatic int zero_index(input logic [31:0] v, input int w);
      int idx;
      idx = 0;
      for (int i = w - 1; i >= 0; i--) begin
         if (!v[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/keypad_col_sync.sv
module keypad_col_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (clr) stg[s] <= '1;
               else if (s == 0) stg[s] <= d;
               else stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/keypad_row_seq.sv
module keypad_row_seq #(
   parameter int ROWS = 4
) (
   input  logic            clk,
   input  logic            clr,
   input  logic            step,
   output logic [ROWS-1:0] row_drv
);

   localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ROWS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clr) cnt <= '0;
      else if (step) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   // Count value k drives row (k-1) mod ROWS low.
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         localparam logic [CNT_W-1:0] SEL = CNT_W'((r + 1) % ROWS);
         assign row_drv[r] = (cnt != SEL);
      end
   endgenerate

endmodule

// File: rtl/keypad_code_lut.sv
module keypad_code_lut
   import keypad_pkg::*;
#(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int CODE_W = 5
) (
   input  logic [ROWS+COLS-1:0] pattern,   // {row drive, column sense}
   output logic [CODE_W-1:0]    code
);

   localparam logic [CODE_W-1:0] NO_KEY = '1;

   logic [31:0] row_v, col_v;
   int          row_zeros, col_zeros, row_idx, col_idx;

   always_comb begin
      row_v = '1;
      col_v = '1;
      row_v[ROWS-1:0] = pattern[ROWS+COLS-1:COLS];
      col_v[COLS-1:0] = pattern[COLS-1:0];
      row_zeros = zero_count(row_v, ROWS);
      col_zeros = zero_count(col_v, COLS);
      row_idx   = zero_index(row_v, ROWS);
      col_idx   = zero_index(col_v, COLS);
      if (row_zeros == 1 && col_zeros == 1)
         code = CODE_W'(row_idx * COLS + col_idx);
      else
         code = NO_KEY;
   end

endmodule

// File: rtl/keypad_scan_enc.sv
module keypad_scan_enc #(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int CODE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              scan_tick,
   input  logic [COLS-1:0]   col_in,
   output logic [ROWS-1:0]   row_drv,
   output logic [CODE_W-1:0] key_code
);

   localparam int KEYS = ROWS * COLS;
   localparam logic [CODE_W-1:0] NO_KEY = '1;

   generate
      if (ROWS < 2 || ROWS > 32) begin : g_bad_rows
         $error("ROWS must be within 2..32");
      end
      if (COLS < 1 || COLS > 32) begin : g_bad_cols
         $error("COLS must be within 1..32");
      end
      if (KEYS >= (1 << CODE_W)) begin : g_bad_code
         $error("CODE_W too narrow to keep the all-ones code free");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [COLS-1:0]   col_s;
   logic [CODE_W-1:0] lut_code;

   keypad_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .clr (clr),
      .d   (col_in),
      .q   (col_s)
   );

   keypad_row_seq #(.ROWS(ROWS)) u_rows (
      .clk     (clk),
      .clr     (clr),
      .step    (scan_tick),
      .row_drv (row_drv)
   );

   keypad_code_lut #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_lut (
      .pattern ({row_drv, col_s}),
      .code    (lut_code)
   );

   // Decode the current row on the tick edge; the row moves on the same edge.
   always_ff @(posedge clk) begin
      if (clr) key_code <= NO_KEY;
      else if (scan_tick) key_code <= lut_code;
   end

endmodule

// File: rtl/keypad_scan_enc_chk.sv
module keypad_scan_enc_chk #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              clr,
   input logic              scan_tick,
   input logic [ROWS-1:0]   row_drv,
   input logic [CODE_W-1:0] key_code
);

   localparam logic [CODE_W-1:0] NO_KEY = '1;
   localparam logic [CODE_W-1:0] MAXK   = CODE_W'(ROWS * COLS);
   localparam logic [ROWS-1:0]   FIRST  = ~(ROWS'(1) << (ROWS - 1));

   // R1
   clear_state_chk: assert property (@(posedge clk)
      clr |=> (row_drv == FIRST && key_code == NO_KEY));

   // R2
   row_step_chk: assert property (@(posedge clk) disable iff (clr)
      scan_tick |=> row_drv == {$past(row_drv[ROWS-2:0]), $past(row_drv[ROWS-1])});

   // R2
   row_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !scan_tick |=> $stable(row_drv));

   // R3
   one_row_chk: assert property (@(posedge clk) disable iff (clr)
      $countones(~row_drv) == 1);

   // R7
   code_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !scan_tick |=> $stable(key_code));

   // R4
   code_range_chk: assert property (@(posedge clk) disable iff (clr)
      (key_code == NO_KEY) || (key_code < MAXK));

endmodule

bind keypad_scan_enc keypad_scan_enc_chk #(
   .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)
) u_chk (
   .clk       (clk),
   .clr       (clr),
   .scan_tick (scan_tick),
   .row_drv   (row_drv),
   .key_code  (key_code)
);

// File: tb/keypad_scan_enc_bench.sv
module keypad_scan_enc_bench;

   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       scan_tick = 1'b0;
   logic [3:0] col_in;
   logic [3:0] row_drv;
   logic [4:0] key_code;

   logic [15:0] pressed = '0;
   logic        force_en = 1'b0;
   logic [3:0]  force_col = 4'hF;
   logic [3:0]  model_col;

   int n_checks = 0;
   int n_fail   = 0;
   int ridx     = 3;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   keypad_scan_enc u_keypad_scan_enc (
      .clk       (clk),
      .clr       (clr),
      .scan_tick (scan_tick),
      .col_in    (col_in),
      .row_drv   (row_drv),
      .key_code  (key_code)
   );

   // Keypad model: a pressed key in a driven row pulls its column low.
   always_comb begin
      model_col = 4'hF;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (!row_drv[r] && pressed[r*4+c]) model_col[c] = 1'b0;
   end
   assign col_in = force_en ? force_col : model_col;

   function automatic int exp_code(input logic [15:0] m, input int r);
      int n, col;
      n = 0; col = 0;
      for (int c = 0; c < 4; c++)
         if (m[r*4+c]) begin n++; col = c; end
      return (n == 1) ? r * 4 + col : 31;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse();
      scan_tick = 1'b1;
      @(negedge clk);
      scan_tick = 1'b0;
      ridx = (ridx + 1) % 4;
   endtask

   // One scan step under the keypad model.
   task automatic scan_step(input string req);
      int e;
      int held;
      e = exp_code(pressed, ridx);
      check("R3 row drive", int'(row_drv), int'(~(4'b1 << ridx) & 4'hF));
      pulse();
      check(req, int'(key_code), e);
      held = int'(key_code);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R7 code holds between ticks", int'(key_code), held);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 row after clear", int'(row_drv), 4'b0111);
      check("R1 code after clear", int'(key_code), 31);
      clr = 1'b0;
      ridx = 3;
      settle();

      // R2: row sequence without keys, and hold without ticks
      for (int i = 0; i < 4; i++) scan_step("R5 empty row");
      check("R2 row holds", int'(row_drv), 4'b0111);

      // R4: every key alone through a full rotation
      for (int k = 0; k < 16; k++) begin
         pressed = 16'(1 << k);
         settle();
         for (int s = 0; s < 4; s++) scan_step("R4 single key");
      end

      // R6: two keys in one row; R4: keys in different rows
      pressed = 16'h0060;
      settle();
      for (int s = 0; s < 4; s++) scan_step("R6 two columns low");
      pressed = 16'h4002;
      settle();
      for (int s = 0; s < 4; s++) scan_step("R4 keys in separate rows");
      pressed = 16'hFFFF;
      settle();
      for (int s = 0; s < 4; s++) scan_step("R6 all keys");
      pressed = '0;

      // R8: synchronizer latency via direct column drive
      force_en = 1'b1;
      force_col = 4'hF;
      settle();
      force_col = 4'b1011;
      repeat (2) @(negedge clk);
      begin
         int e;
         e = ridx * 4 + 2;
         pulse();
         check("R8 change two edges before tick", int'(key_code), e);
      end
      force_col = 4'hF;
      settle();
      force_col = 4'b1101;
      @(negedge clk);
      pulse();
      check("R8 change one edge before tick", int'(key_code), 31);
      settle();
      begin
         int e;
         e = ridx * 4 + 1;
         pulse();
         check("R8 late change seen next tick", int'(key_code), e);
      end
      force_en = 1'b0;
      force_col = 4'hF;

      // R1: clear in mid-run
      pressed = 16'h0001;
      settle();
      while (ridx != 0) scan_step("R4 before clear");
      pulse();
      check("R4 code before clear", int'(key_code), 0);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      ridx = 3;
      check("R1 row after mid-run clear", int'(row_drv), 4'b0111);
      check("R1 code after mid-run clear", int'(key_code), 31);
      pressed = '0;
      settle();
      scan_step("R5 after clear");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule